// File: doc/BRIEF.md
# Converter Offset Calibration Sequencer

This block times the offset-calibration period of an audio converter's serial interface. A calibration period opens on the first clock after the reset input is released, and again whenever the mode line moves from control mode to data mode. While the period runs, the block counts frame-sync rising edges, zeroes the serial output data and raises the A/D-invalid status bit in its fixed place in the frame. When the frame count reaches its limit, it closes the period with a one-cycle done pulse.

The block also captures the input-select bit at the start of each period. This bit chooses which input channel the analog side calibrates, and the captured copy is held steady for the whole period. The analog calibration and the settling time after power-up are outside the block. A system meets the settling time by holding reset low, or by staying in control mode, for long enough. All inputs are synchronous to `clk_i`. Frame position (slot and bit index) comes from the serializer that shares the frame.

Top module: `offset_cal_seq`

## Requirements
- R1: While `rst_ni` is low, `cal_busy_o` and `mute_o` are 1, `cal_done_o` is 0 and `in_sel_cal_o` is 0. On the first rising clock edge after release, a calibration period starts.
- R2: A calibration period starts on the clock edge at which `data_mode_i` is sampled 1 after having been sampled 0 on the edge before. A falling edge of `data_mode_i`, or a steady level, starts nothing and does not end a running period.
- R3: A period ends (`cal_busy_o` falls) on the edge that samples the 194th rising edge of `fsync_i` after the start edge. A frame-sync rise sampled on the start edge is not counted.
- R4: `cal_done_o` is high for exactly one cycle. It rises on the same edge on which `cal_busy_o` falls, and at no other time.
- R5: While `cal_busy_o` is 1, `sd_o` is 0 at every frame position other than the flag position. While it is 0, `sd_o` equals `sd_i` there.
- R6: The flag position is slot index 6 (`slot_idx_i` = 6) with bit index 7 (`bit_idx_i` = 7). There `adi_o` and `sd_o` equal `cal_busy_o`. Elsewhere `adi_o` is 0.
- R7: `in_sel_cal_o` takes the value of `in_sel_i` on each start edge and keeps it until the next start. Changes of `in_sel_i` in between have no effect.
- R8: A start during a running period restarts the frame count from zero. The period then lasts 194 frame-sync rises from that restart.
- R9: Only rising edges of `fsync_i` are counted. A high level lasting several cycles counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low (device reset) |
| data_mode_i | input | 1 | 1 = data mode, 0 = control mode |
| fsync_i | input | 1 | Frame sync, synchronous to clk_i |
| in_sel_i | input | 1 | Input-channel select |
| slot_idx_i | input | 3 | Current output time slot |
| bit_idx_i | input | 3 | Current bit within the slot |
| sd_i | input | 1 | Serial output data from the formatter |
| cal_busy_o | output | 1 | Calibration period running |
| cal_done_o | output | 1 | One-cycle pulse at end of calibration |
| mute_o | output | 1 | Serial data forced to zero |
| adi_o | output | 1 | A/D-invalid bit, high only at its slot/bit position |
| sd_o | output | 1 | Serial output data after muting and flag insertion |
| in_sel_cal_o | output | 1 | Input select captured for calibration |

## Verification
The assertions assume that `fsync_i`, `data_mode_i` and the frame position are already synchronous to `clk_i`. They also assume that the slot and bit indexes change only with the clock, so any sampled edge of these inputs is a real edge. The stimulus drives every input on the falling clock edge. It holds frame sync high for two cycles and low for two, and it toggles the mode line only while frame sync is low, so a restart never coincides with a counted frame.

// File: rtl/offset_cal_pkg.sv
package offset_cal_pkg;
  localparam int unsigned CAL_FRAMES = 194;
  localparam int unsigned POS_W      = 3;
  localparam int unsigned FLAG_SLOT  = 6;
  localparam int unsigned FLAG_BIT   = 7;

  typedef enum logic [1:0] {
    TRIG_NONE = 2'd0,
    TRIG_BOOT = 2'd1,
    TRIG_MODE = 2'd2
  } trig_src_e;
endpackage

// File: rtl/offset_cal_trig.sv
module offset_cal_trig
  import offset_cal_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      data_mode_i,
  input  logic      fsync_i,
  output trig_src_e trig_o,
  output logic      fs_rise_o
);
  logic boot_q;
  logic mode_q;
  logic fs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q <= 1'b1;
      mode_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      boot_q <= 1'b0;
      mode_q <= data_mode_i;
      fs_q   <= fsync_i;
    end
  end

  always_comb begin
    if (boot_q)                      trig_o = TRIG_BOOT;
    else if (data_mode_i && !mode_q) trig_o = TRIG_MODE;
    else                             trig_o = TRIG_NONE;
  end

  assign fs_rise_o = fsync_i & ~fs_q;
endmodule

// File: rtl/offset_cal_frame_ctr.sv
module offset_cal_frame_ctr #(
  parameter int unsigned FRAMES = 194
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fs_rise_i,
  input  logic in_sel_i,
  output logic busy_o,
  output logic done_o,
  output logic in_sel_cal_o
);
  localparam int unsigned CNT_W = $clog2(FRAMES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAMES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      busy_o       <= 1'b1;
      done_o       <= 1'b0;
      in_sel_cal_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        cnt_q        <= '0;
        busy_o       <= 1'b1;
        in_sel_cal_o <= in_sel_i;
      end else if (busy_o && fs_rise_i) begin
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/offset_cal_slot_mux.sv
module offset_cal_slot_mux #(
  parameter int unsigned POS_W     = 3,
  parameter int unsigned FLAG_SLOT = 6,
  parameter int unsigned FLAG_BIT  = 7
) (
  input  logic [POS_W-1:0] slot_idx_i,
  input  logic [POS_W-1:0] bit_idx_i,
  input  logic             busy_i,
  input  logic             sd_i,
  output logic             adi_o,
  output logic             sd_o
);
  logic at_flag;

  assign at_flag = (slot_idx_i == POS_W'(FLAG_SLOT)) && (bit_idx_i == POS_W'(FLAG_BIT));
  assign adi_o   = at_flag & busy_i;

  always_comb begin
    if (at_flag)     sd_o = busy_i;
    else if (busy_i) sd_o = 1'b0;
    else             sd_o = sd_i;
  end
endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq
  import offset_cal_pkg::*;
#(
  parameter int unsigned FRAMES = CAL_FRAMES,
  parameter int unsigned PW     = POS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          data_mode_i,
  input  logic          fsync_i,
  input  logic          in_sel_i,
  input  logic [PW-1:0] slot_idx_i,
  input  logic [PW-1:0] bit_idx_i,
  input  logic          sd_i,
  output logic          cal_busy_o,
  output logic          cal_done_o,
  output logic          mute_o,
  output logic          adi_o,
  output logic          sd_o,
  output logic          in_sel_cal_o
);
  trig_src_e trig;
  logic      fs_rise;
  logic      busy;

  offset_cal_trig u_trig (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .data_mode_i (data_mode_i),
    .fsync_i     (fsync_i),
    .trig_o      (trig),
    .fs_rise_o   (fs_rise)
  );

  offset_cal_frame_ctr #(.FRAMES(FRAMES)) u_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (trig != TRIG_NONE),
    .fs_rise_i    (fs_rise),
    .in_sel_i     (in_sel_i),
    .busy_o       (busy),
    .done_o       (cal_done_o),
    .in_sel_cal_o (in_sel_cal_o)
  );

  offset_cal_slot_mux #(
    .POS_W     (PW),
    .FLAG_SLOT (FLAG_SLOT),
    .FLAG_BIT  (FLAG_BIT)
  ) u_mux (
    .slot_idx_i (slot_idx_i),
    .bit_idx_i  (bit_idx_i),
    .busy_i     (busy),
    .sd_i       (sd_i),
    .adi_o      (adi_o),
    .sd_o       (sd_o)
  );

  assign cal_busy_o = busy;
  assign mute_o     = busy;
endmodule

// File: rtl/offset_cal_seq_chk.sv
module offset_cal_seq_chk #(
  parameter int unsigned PW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          data_mode_i,
  input logic          in_sel_i,
  input logic [PW-1:0] slot_idx_i,
  input logic [PW-1:0] bit_idx_i,
  input logic          sd_i,
  input logic          cal_busy_o,
  input logic          cal_done_o,
  input logic          adi_o,
  input logic          sd_o,
  input logic          in_sel_cal_o
);
  logic [1:0] age_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  assign warm = (age_q == 2'd3);

  logic at_flag;
  assign at_flag = (slot_idx_i == PW'(6)) && (bit_idx_i == PW'(7));

  // R4
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_done_o |=> !cal_done_o);

  // R4
  done_with_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && cal_done_o) |-> (!cal_busy_o && $past(cal_busy_o)));

  // R2
  mode_rise_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $rose(data_mode_i)) |=> cal_busy_o);

  // R5
  mute_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_busy_o && !at_flag) |-> !sd_o);

  // R5
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cal_busy_o && !at_flag) |-> (sd_o == sd_i));

  // R6
  adi_place_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adi_o |-> (at_flag && cal_busy_o && sd_o));

  // R7
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(cal_busy_o) && !($past(data_mode_i) && !$past(data_mode_i, 2)))
      |-> $stable(in_sel_cal_o));
endmodule

bind offset_cal_seq offset_cal_seq_chk #(.PW(PW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .data_mode_i  (data_mode_i),
  .in_sel_i     (in_sel_i),
  .slot_idx_i   (slot_idx_i),
  .bit_idx_i    (bit_idx_i),
  .sd_i         (sd_i),
  .cal_busy_o   (cal_busy_o),
  .cal_done_o   (cal_done_o),
  .adi_o        (adi_o),
  .sd_o         (sd_o),
  .in_sel_cal_o (in_sel_cal_o)
);

// File: tb/tb_offset_cal_seq.sv
`timescale 1ns/1ps
module tb_offset_cal_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic       fs = 1'b0;
  logic       isel = 1'b0;
  logic [2:0] slot = 3'd0;
  logic [2:0] bitx = 3'd0;
  logic       sdi = 1'b1;
  logic       busy, done, mute, adi, sdo, iscal;
  int         n_chk = 0;
  int         n_err = 0;

  always #5 clk = ~clk;

  offset_cal_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .data_mode_i(mode), .fsync_i(fs),
    .in_sel_i(isel), .slot_idx_i(slot), .bit_idx_i(bitx), .sd_i(sdi),
    .cal_busy_o(busy), .cal_done_o(done), .mute_o(mute), .adi_o(adi),
    .sd_o(sdo), .in_sel_cal_o(iscal)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one frame: fsync high two cycles (R9: counted once), low two cycles
  task automatic frame();
    fs = 1'b1; @(negedge clk); @(negedge clk);
    fs = 1'b0; @(negedge clk); @(negedge clk);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) frame();
  endtask

  // final frame of a period: check the end timing
  task automatic last_frame(input string req);
    fs = 1'b1; @(negedge clk);
    chk({req, " busy falls"}, busy, 1'b0);
    chk("R4 done pulse", done, 1'b1);
    @(negedge clk);
    chk("R4 done one cycle", done, 1'b0);
    chk("R9 held fsync no recount", busy, 1'b0);
    fs = 1'b0; @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy in reset", busy, 1'b1);
    chk("R1 mute in reset", mute, 1'b1);
    chk("R1 done in reset", done, 1'b0);
    chk("R1 sel in reset", iscal, 1'b0);
    chk("R5 muted in reset", sdo, 1'b0);
    isel = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 boot start latches sel", iscal, 1'b1);
    chk("R1 busy after boot", busy, 1'b1);
  endtask

  task automatic t_boot_run();
    isel = 1'b0;
    frames(193);
    chk("R3 busy after 193 frames", busy, 1'b1);
    chk("R7 sel held", iscal, 1'b1);
    last_frame("R3");
    chk("R5 pass-through 1", sdo, 1'b1);
    sdi = 1'b0; @(negedge clk);
    chk("R5 pass-through 0", sdo, 1'b0);
    sdi = 1'b1;
  endtask

  task automatic t_flag_pos();
    slot = 3'd6; bitx = 3'd7; @(negedge clk);
    chk("R6 adi low when idle", adi, 1'b0);
    chk("R6 sd flag low when idle", sdo, 1'b0);
    mode = 1'b1; @(negedge clk);
    chk("R2 mode rise starts", busy, 1'b1);
    chk("R6 adi high in cal", adi, 1'b1);
    chk("R6 sd flag high in cal", sdo, 1'b1);
    chk("R7 sel latched 0", iscal, 1'b0);
    slot = 3'd6; bitx = 3'd6; @(negedge clk);
    chk("R6 adi off position", adi, 1'b0);
    chk("R5 muted off position", sdo, 1'b0);
    slot = 3'd0; bitx = 3'd0;
    isel = 1'b1; @(negedge clk);
    chk("R7 sel change ignored", iscal, 1'b0);
    mode = 1'b0; @(negedge clk);
    chk("R2 mode fall ignored", busy, 1'b1);
    frames(193);
    chk("R3 busy 193 frames mode", busy, 1'b1);
    last_frame("R3");
  endtask

  task automatic t_restart();
    mode = 1'b0; @(negedge clk);
    chk("R2 fall does not start", busy, 1'b0);
    isel = 1'b1; mode = 1'b1; @(negedge clk);
    chk("R7 sel latched 1", iscal, 1'b1);
    frames(100);
    mode = 1'b0; @(negedge clk);
    isel = 1'b0; mode = 1'b1; @(negedge clk);
    chk("R8 relatch on restart", iscal, 1'b0);
    frames(193);
    chk("R8 busy after restart 193", busy, 1'b1);
    last_frame("R8");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_boot_run();
        t_flag_pos();
        t_restart();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule